// File: doc/BRIEF.md
# Inbound PCI Address Window Translator

This block sits in a PCI host bridge. It turns addresses that bus-master devices put on the PCI side into local memory addresses. Three inbound windows are available. Each window has a 64-bit size/attribute mask and a 64-bit local base. Software programs both through a 32-bit register port that shares the bridge's register space, one 32-bit half at a time.

A window is open when bit 0 of its mask is set. Every window starts at PCI address 0. An address falls inside a window when it has no bit set where the mask, with its three attribute bits cleared, has a one. The translated address is the window's local base plus the PCI address. When more than one window matches, the lowest-numbered window is used.

Each lookup request returns a result one clock later: a hit flag, the index of the window used, and the 64-bit local address.

Top module: `inwin_xlate`

## Requirements
- R1: After reset every mask holds 0xFFFFFFFF_00000000 and every local base holds 0. No lookup hits until software opens a window.
- R2: The register byte offsets are fixed:
  - window 0: mask low 0x98, mask high 0xF8, base low 0x9C, base high 0xA0;
  - window 1: mask 0xA4, base low 0xA8, base high 0xAC;
  - window 2: mask low 0xB0, mask high 0xFC, base low 0xB4, base high 0xB8.
  Read data appears on `cfg_rd_data`, with `cfg_rd_valid` high, one cycle after `cfg_rd_en`.
- R3: Writing one 32-bit half of a 64-bit mask or base changes only that half. The other half keeps its value.
- R4: Window 1 has only one 32-bit mask register. A write to it sets the upper 32 mask bits to zero. Reading it returns the lower 32 bits.
- R5: A window whose mask bit 0 is 0 never hits.
- R6: An open window hits when (address AND (mask with bits 2..0 cleared)) is zero. Mask bits 2..0 have no effect on matching.
- R7: The local address is the base plus the PCI address, modulo 2^64.
- R8: When several open windows hit, the result reports the lowest window index. `res_win` carries 0, 1 or 2.
- R9: `res_valid` is high exactly one cycle after `xl_valid`. A miss reports hit 0, window 0 and address 0.
- R10: Reads of any other offset return 0. Writes to any other offset change no window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_off | input | 8 | Register write byte offset |
| cfg_wr_data | input | 32 | Register write data |
| cfg_rd_en | input | 1 | Register read strobe |
| cfg_rd_off | input | 8 | Register read byte offset |
| cfg_rd_data | output | 32 | Read data, one cycle after the strobe |
| cfg_rd_valid | output | 1 | Read data valid |
| xl_valid | input | 1 | Lookup request |
| xl_addr | input | 64 | PCI-side address to translate |
| res_valid | output | 1 | Lookup result valid |
| res_hit | output | 1 | Address fell into an open window |
| res_win | output | 2 | Index of the window used |
| res_addr | output | 64 | Translated local address |

## Verification
Both a register read and a lookup produce their result exactly one clock after the strobe, through a single output register. A register write affects lookups sampled from the next clock on. The bench drives every stimulus on a falling edge. A lookup pushes its expected item into a queue, and a monitor pops and compares the item on the following falling edge, when the result register has settled. Read data is compared on the falling edge one cycle after the strobe, so no check depends on which process runs first at a rising edge.

// File: rtl/inwin_pkg.sv
package inwin_pkg;
    localparam int NWIN   = 3;
    localparam int WIN_W  = 2;
    localparam int ADDR_W = 64;
    localparam int DATA_W = 32;
    localparam int OFF_W  = 8;
    localparam int ATTR_W = 3;

    localparam logic [ADDR_W-1:0] MASK_RST = 64'hFFFF_FFFF_0000_0000;

    typedef enum logic [2:0] {
        FLD_NONE,
        FLD_MASK_LO,
        FLD_MASK_HI,
        FLD_MASK_NARROW,
        FLD_BASE_LO,
        FLD_BASE_HI
    } fld_e;

    typedef struct packed {
        logic [WIN_W-1:0] win;
        fld_e             fld;
    } regsel_t;

    // Offset map: the bridge register decoder relies on these positions.
    function automatic regsel_t decode_off(input logic [OFF_W-1:0] off);
        regsel_t s;
        s.win = '0;
        s.fld = FLD_NONE;
        case (off)
            8'h98: begin s.win = 2'd0; s.fld = FLD_MASK_LO;     end
            8'hF8: begin s.win = 2'd0; s.fld = FLD_MASK_HI;     end
            8'h9C: begin s.win = 2'd0; s.fld = FLD_BASE_LO;     end
            8'hA0: begin s.win = 2'd0; s.fld = FLD_BASE_HI;     end
            8'hA4: begin s.win = 2'd1; s.fld = FLD_MASK_NARROW; end
            8'hA8: begin s.win = 2'd1; s.fld = FLD_BASE_LO;     end
            8'hAC: begin s.win = 2'd1; s.fld = FLD_BASE_HI;     end
            8'hB0: begin s.win = 2'd2; s.fld = FLD_MASK_LO;     end
            8'hFC: begin s.win = 2'd2; s.fld = FLD_MASK_HI;     end
            8'hB4: begin s.win = 2'd2; s.fld = FLD_BASE_LO;     end
            8'hB8: begin s.win = 2'd2; s.fld = FLD_BASE_HI;     end
            default: ;
        endcase
        return s;
    endfunction
endpackage

// File: rtl/inwin_regs.sv
module inwin_regs
    import inwin_pkg::*;
#(
    parameter int N  = NWIN,
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int OW = OFF_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [OW-1:0]         wr_off,
    input  logic [DW-1:0]         wr_data,
    input  logic                  rd_en,
    input  logic [OW-1:0]         rd_off,
    output logic [DW-1:0]         rd_data,
    output logic                  rd_valid,
    output logic [N-1:0][AW-1:0]  mask_o,
    output logic [N-1:0][AW-1:0]  base_o
);
    typedef struct packed {
        logic [N-1:0][AW-1:0] mask;
        logic [N-1:0][AW-1:0] base;
        logic [DW-1:0]        rdat;
        logic                 rvld;
    } reg_st_t;

    reg_st_t st_d, st_q;
    regsel_t wsel, rsel;
    logic    wsel_ok, rsel_ok;

    always_comb begin
        wsel    = decode_off(wr_off);
        rsel    = decode_off(rd_off);
        wsel_ok = (wsel.fld != FLD_NONE) && (int'(wsel.win) < N);
        rsel_ok = (rsel.fld != FLD_NONE) && (int'(rsel.win) < N);
        st_d    = st_q;

        if (wr_en && wsel_ok) begin
            case (wsel.fld)
                FLD_MASK_LO:     st_d.mask[wsel.win][DW-1:0]  = wr_data;
                FLD_MASK_HI:     st_d.mask[wsel.win][AW-1:DW] = wr_data;
                FLD_MASK_NARROW: st_d.mask[wsel.win]          = AW'(wr_data);
                FLD_BASE_LO:     st_d.base[wsel.win][DW-1:0]  = wr_data;
                FLD_BASE_HI:     st_d.base[wsel.win][AW-1:DW] = wr_data;
                default: ;
            endcase
        end

        st_d.rvld = rd_en;
        st_d.rdat = '0;
        if (rd_en && rsel_ok) begin
            case (rsel.fld)
                FLD_MASK_LO,
                FLD_MASK_NARROW: st_d.rdat = st_q.mask[rsel.win][DW-1:0];
                FLD_MASK_HI:     st_d.rdat = st_q.mask[rsel.win][AW-1:DW];
                FLD_BASE_LO:     st_d.rdat = st_q.base[rsel.win][DW-1:0];
                FLD_BASE_HI:     st_d.rdat = st_q.base[rsel.win][AW-1:DW];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                st_q.mask[i] <= MASK_RST;
                st_q.base[i] <= '0;
            end
            st_q.rdat <= '0;
            st_q.rvld <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data  = st_q.rdat;
    assign rd_valid = st_q.rvld;
    assign mask_o   = st_q.mask;
    assign base_o   = st_q.base;
endmodule

// File: rtl/inwin_match.sv
module inwin_match
    import inwin_pkg::*;
#(
    parameter int N  = NWIN,
    parameter int AW = ADDR_W,
    parameter int AT = ATTR_W
) (
    input  logic [N-1:0][AW-1:0] mask_i,
    input  logic [AW-1:0]        addr_i,
    output logic [N-1:0]         hit_o
);
    for (genvar g = 0; g < N; g++) begin : g_win
        logic [AW-1:0] size_bits;
        logic          open;
        assign size_bits = {mask_i[g][AW-1:AT], {AT{1'b0}}};
        assign open      = mask_i[g][0];
        assign hit_o[g]  = open && ((addr_i & size_bits) == '0);
    end
endmodule

// File: rtl/inwin_select.sv
module inwin_select
    import inwin_pkg::*;
#(
    parameter int N  = NWIN,
    parameter int AW = ADDR_W,
    parameter int WW = WIN_W
) (
    input  logic [N-1:0]         hit_i,
    input  logic [N-1:0][AW-1:0] base_i,
    input  logic [AW-1:0]        addr_i,
    output logic                 any_o,
    output logic [WW-1:0]        win_o,
    output logic [AW-1:0]        local_o
);
    logic [AW-1:0] base_sel;

    always_comb begin
        any_o    = 1'b0;
        win_o    = '0;
        base_sel = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit_i[i]) begin
                any_o    = 1'b1;
                win_o    = WW'(i);
                base_sel = base_i[i];
            end
        end
        local_o = any_o ? (base_sel + addr_i) : '0;
    end
endmodule

// File: rtl/inwin_xlate.sv
module inwin_xlate
    import inwin_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr_en,
    input  logic [OFF_W-1:0]    cfg_wr_off,
    input  logic [DATA_W-1:0]   cfg_wr_data,
    input  logic                cfg_rd_en,
    input  logic [OFF_W-1:0]    cfg_rd_off,
    output logic [DATA_W-1:0]   cfg_rd_data,
    output logic                cfg_rd_valid,
    input  logic                xl_valid,
    input  logic [ADDR_W-1:0]   xl_addr,
    output logic                res_valid,
    output logic                res_hit,
    output logic [WIN_W-1:0]    res_win,
    output logic [ADDR_W-1:0]   res_addr
);
    typedef struct packed {
        logic              vld;
        logic              hit;
        logic [WIN_W-1:0]  win;
        logic [ADDR_W-1:0] addr;
    } res_st_t;

    logic [NWIN-1:0][ADDR_W-1:0] mask_w, base_w;
    logic [NWIN-1:0]             hit_w;
    logic                        any_w;
    logic [WIN_W-1:0]            win_w;
    logic [ADDR_W-1:0]           local_w;
    res_st_t                     res_d, res_q;

    inwin_regs #(.N(NWIN), .AW(ADDR_W), .DW(DATA_W), .OW(OFF_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_wr_en),
        .wr_off   (cfg_wr_off),
        .wr_data  (cfg_wr_data),
        .rd_en    (cfg_rd_en),
        .rd_off   (cfg_rd_off),
        .rd_data  (cfg_rd_data),
        .rd_valid (cfg_rd_valid),
        .mask_o   (mask_w),
        .base_o   (base_w)
    );

    inwin_match #(.N(NWIN), .AW(ADDR_W), .AT(ATTR_W)) u_match (
        .mask_i (mask_w),
        .addr_i (xl_addr),
        .hit_o  (hit_w)
    );

    inwin_select #(.N(NWIN), .AW(ADDR_W), .WW(WIN_W)) u_sel (
        .hit_i   (hit_w),
        .base_i  (base_w),
        .addr_i  (xl_addr),
        .any_o   (any_w),
        .win_o   (win_w),
        .local_o (local_w)
    );

    always_comb begin
        res_d      = '0;
        res_d.vld  = xl_valid;
        if (xl_valid && any_w) begin
            res_d.hit  = 1'b1;
            res_d.win  = win_w;
            res_d.addr = local_w;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign res_valid = res_q.vld;
    assign res_hit   = res_q.hit;
    assign res_win   = res_q.win;
    assign res_addr  = res_q.addr;
endmodule

// File: rtl/inwin_xlate_chk.sv
module inwin_xlate_chk
    import inwin_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_rd_en,
    input logic              cfg_rd_valid,
    input logic              xl_valid,
    input logic              res_valid,
    input logic              res_hit,
    input logic [WIN_W-1:0]  res_win,
    input logic [ADDR_W-1:0] res_addr
);
    assert_res_follows_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        xl_valid |=> res_valid);
    assert_res_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !xl_valid |=> !res_valid);
    assert_hit_needs_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        res_hit |-> res_valid);
    assert_miss_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_hit) |-> (res_addr == '0 && res_win == '0));
    assert_win_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        res_hit |-> (int'(res_win) < NWIN));
    assert_rd_timing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rd_en |=> cfg_rd_valid);
endmodule

bind inwin_xlate inwin_xlate_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_rd_en    (cfg_rd_en),
    .cfg_rd_valid (cfg_rd_valid),
    .xl_valid     (xl_valid),
    .res_valid    (res_valid),
    .res_hit      (res_hit),
    .res_win      (res_win),
    .res_addr     (res_addr)
);

// File: tb/inwin_xlate_bench.sv
module inwin_xlate_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [7:0]  cfg_wr_off = '0;
    logic [31:0] cfg_wr_data = '0;
    logic        cfg_rd_en = 1'b0;
    logic [7:0]  cfg_rd_off = '0;
    logic [31:0] cfg_rd_data;
    logic        cfg_rd_valid;
    logic        xl_valid = 1'b0;
    logic [63:0] xl_addr = '0;
    logic        res_valid;
    logic        res_hit;
    logic [1:0]  res_win;
    logic [63:0] res_addr;

    typedef struct {
        logic        hit;
        logic [1:0]  win;
        logic [63:0] addr;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    always #10 clk = ~clk;

    inwin_xlate u_inwin_xlate (.*);

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic wr(input logic [7:0] off, input logic [31:0] data);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_off = off; cfg_wr_data = data;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] off, input logic [31:0] exp, input string tag);
        @(negedge clk);
        cfg_rd_en = 1'b1; cfg_rd_off = off;
        @(negedge clk);
        cfg_rd_en = 1'b0;
        check(cfg_rd_valid === 1'b1, {tag, " rd_valid"}, 64'(cfg_rd_valid), 64'd1);
        check(cfg_rd_data === exp, tag, 64'(cfg_rd_data), 64'(exp));
    endtask

    task automatic req(input logic [63:0] a, input logic h, input logic [1:0] w,
                       input logic [63:0] la, input string tag);
        exp_t e;
        e.hit = h; e.win = w; e.addr = la; e.tag = tag;
        @(negedge clk);
        xl_valid = 1'b1; xl_addr = a;
        exp_q.push_back(e);
        @(negedge clk);
        xl_valid = 1'b0;
    endtask

    // Monitor: pops one expected item per result.
    always @(negedge clk) begin
        if (rst_n && res_valid === 1'b1) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9 unexpected result", 64'd1, 64'd0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(res_hit === e.hit, {e.tag, " hit"}, 64'(res_hit), 64'(e.hit));
                check(res_win === e.win, {e.tag, " win"}, 64'(res_win), 64'(e.win));
                check(res_addr === e.addr, {e.tag, " addr"}, res_addr, e.addr);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog expired", 64'd0, 64'd1);
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(res_valid === 1'b0, "R9 reset res_valid", 64'(res_valid), 64'd0);
        check(cfg_rd_valid === 1'b0, "R2 reset rd_valid", 64'(cfg_rd_valid), 64'd0);

        // R1 reset values, R2 offsets
        rd(8'h98, 32'h0000_0000, "R1 w0 mask low");
        rd(8'hF8, 32'hFFFF_FFFF, "R1 w0 mask high");
        rd(8'hFC, 32'hFFFF_FFFF, "R1 w2 mask high");
        rd(8'hA4, 32'h0000_0000, "R1 w1 mask");
        rd(8'h9C, 32'h0000_0000, "R1 w0 base low");
        rd(8'hB8, 32'h0000_0000, "R1 w2 base high");
        req(64'h0, 1'b0, 2'd0, 64'h0, "R1 miss after reset");

        // Window 0: 1 MiB, base 0x1_4000_0000
        wr(8'h98, 32'hFFF0_0001);
        wr(8'h9C, 32'h4000_0000);
        wr(8'hA0, 32'h0000_0001);
        req(64'h12345, 1'b1, 2'd0, 64'h1_4001_2345, "R7 w0 translate");
        req(64'h10_0000, 1'b0, 2'd0, 64'h0, "R6 just past w0");

        // R3 half write
        wr(8'hA0, 32'h0000_0002);
        rd(8'h9C, 32'h4000_0000, "R3 base low kept");
        rd(8'hA0, 32'h0000_0002, "R3 base high new");
        rd(8'hF8, 32'hFFFF_FFFF, "R3 mask high kept");

        // R5 enable bit
        wr(8'hB4, 32'h0000_8000);
        wr(8'hB0, 32'hFFFF_0006);
        wr(8'h98, 32'hFFF0_0000);
        req(64'h10, 1'b0, 2'd0, 64'h0, "R5 closed windows miss");
        rd(8'hB0, 32'hFFFF_0006, "R2 w2 mask low");

        // R6 attribute bits ignored
        wr(8'hB0, 32'hFFFF_0007);
        req(64'h10, 1'b1, 2'd2, 64'h8010, "R6 w2 attr bits ignored");
        req(64'hFFF8, 1'b1, 2'd2, 64'h1_7FF8, "R6 w2 top of range");

        // R8 priority
        wr(8'h98, 32'hFFF0_0001);
        req(64'h10, 1'b1, 2'd0, 64'h2_4000_0010, "R8 w0 over w2");
        req(64'h2_0000, 1'b1, 2'd0, 64'h2_4002_0000, "R8 w0 only");

        // R4 narrow mask of window 1
        wr(8'hA4, 32'hFFFF_F001);
        wr(8'hA8, 32'h0000_1000);
        wr(8'hAC, 32'h0000_0000);
        rd(8'hA4, 32'hFFFF_F001, "R4 w1 mask read");
        req(64'h5_0000_0800, 1'b1, 2'd1, 64'h5_0000_1800, "R4 w1 zero-extended mask");

        // R10 unmapped offsets
        rd(8'h00, 32'h0, "R10 unmapped read");
        wr(8'hC0, 32'hDEAD_BEEF);
        wr(8'hF4, 32'h0000_0000);
        rd(8'hC0, 32'h0, "R10 written unmapped read");
        req(64'h10, 1'b1, 2'd0, 64'h2_4000_0010, "R10 windows unchanged");

        // R7 wrap
        wr(8'h9C, 32'hFFFF_FFF0);
        wr(8'hA0, 32'hFFFF_FFFF);
        req(64'h20, 1'b1, 2'd0, 64'h10, "R7 base wrap");

        // R2 window 2 high mask
        wr(8'hFC, 32'h0000_0000);
        rd(8'hFC, 32'h0, "R2 w2 mask high");
        req(64'h7_0000_F004, 1'b1, 2'd2, 64'h7_0001_7004, "R2 w2 wide window");

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R9 all results seen", 64'(exp_q.size()), 64'd0);
        done = 1'b1;
        summary();
    end
endmodule